// File: doc/BRIEF.md
# Four-Tap Polyphase Overlay Line Resampler

This block resizes one line of a graphics overlay in the horizontal direction, for one colour component. A line of `cfg_src_width` pixels arrives on a valid/ready stream and is held in a single-line store. The block then emits `cfg_dst_width` pixels. Each output pixel is a four-tap weighted sum of neighbouring source pixels. A fixed-point phase accumulator chooses the weights and the centre source pixel.

Software programs the step as the ratio of source width to destination width, with 24 fraction bits. It loads a 33-word coefficient table through a small write port: one index write, then data words written one after another. The table stores half a pixel of phases, and the other half is derived by mirroring. When either of the two enable inputs is low, the stream bypasses the filter unchanged.

Top module: `ovl_hresampler`

## Requirements
- R1: After reset, with both enables high, `in_ready` is 1 and `out_valid` is 0. The table write pointer is 0 and the phase accumulator is 0.
- R2: A coefficient write with `coef_sel`=0 sets the write pointer to `coef_wdata`, saturated at 33. A write with `coef_sel`=1 stores `coef_wdata` at the pointer and increments the pointer when the pointer is below 33. At a pointer of 33 the write is dropped and wraps nowhere. Each word holds tap0 in bits 31:24, tap1 in 23:16, tap2 in 15:8 and tap3 in 7:0.
- R3: When `cfg_scale_en` or `cfg_path_en` is low, the filter is bypassed. `out_valid` equals `in_valid`, `out_data` equals `in_data` and `in_ready` equals `out_ready` in the same cycle, and the filter engine accepts nothing.
- R4: In scaling mode the block accepts exactly `cfg_src_width` pixels, with `in_ready` high. It then holds `in_ready` low until `cfg_dst_width` pixels have been delivered, and raises it again in the cycle after the last one is taken.
- R5: Output pixel n uses the accumulator value n*`cfg_step`, so the initial phase is zero. The centre source pixel is the accumulator shifted right by 24. `cfg_step` is (source width << 24) / destination width, in 28 bits.
- R6: The phase index is accumulator bits 23:18. An index from 0 to 32 uses that table entry as stored. An index from 33 to 63 uses entry 64-index with the four taps in reverse order.
- R7: Tap k (0..3) weights source pixel centre-1+k. A position below 0 reads pixel 0, and a position beyond the last pixel reads the last pixel.
- R8: The weighted sum is rounded by adding 64 and shifting right arithmetically by 7. It is then clamped to the range 0..255.
- R9: The first output is valid one clock after the last input of a line is accepted. While `out_valid` is high and `out_ready` is low, `out_data` holds.
- R10: With both widths equal and `cfg_step` = 1<<24, every phase is 0. With entry 0 = (0,128,0,0), the output reproduces the input line.
- R11: A tap byte of 0x80 means +128. Every other tap byte is a two's-complement value from -127 to 127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_scale_en | input | 1 | Scaler enable |
| cfg_path_en | input | 1 | Scaler path enable |
| cfg_src_width | input | 7 | Source line width, 1..64 |
| cfg_dst_width | input | 7 | Destination line width, 1..64 |
| cfg_step | input | 28 | Phase step, 4.24 fixed point |
| coef_wr | input | 1 | Coefficient port write strobe |
| coef_sel | input | 1 | 0 = index write, 1 = data write |
| coef_wdata | input | 32 | Coefficient port write data |
| in_valid | input | 1 | Source pixel valid |
| in_ready | output | 1 | Source pixel ready |
| in_data | input | 8 | Source pixel |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Output pixel ready |
| out_data | output | 8 | Output pixel |

## Verification
Bypass results are combinational, so the bench checks them one time step after it drives the inputs, between clock edges. In scaling mode `out_valid` must still be low at the falling edge after the last input is accepted and must be high at the next falling edge. The bench checks both points and checks that `in_ready` is low in that gap. Output pixels are compared against a model at each falling edge where both `out_valid` and `out_ready` are high. When the bench holds `out_ready` low, it compares `out_data` again at the next falling edge. `in_ready` is checked at the falling edge after the clock edge that consumes the last output.

// File: rtl/ovl_rs_pkg.sv
package ovl_rs_pkg;
   typedef enum logic {
      RS_FILL = 1'b0,
      RS_EMIT = 1'b1
   } rs_state_e;

   localparam logic COEF_PORT_INDEX = 1'b0;
   localparam logic COEF_PORT_DATA  = 1'b1;
endpackage

// File: rtl/ovl_rs_coef_bank.sv
module ovl_rs_coef_bank
   import ovl_rs_pkg::*;
#(
   parameter int ENTRIES = 33,
   parameter int TAPS    = 4,
   parameter int COEF_W  = 8,
   parameter int IDX_W   = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic                     wr_sel,
   input  logic [TAPS*COEF_W-1:0]   wr_data,
   input  logic [IDX_W-1:0]         ph_idx,
   output logic [TAPS*COEF_W-1:0]   taps_flat
);
   localparam int WORD_W = TAPS * COEF_W;
   localparam int PTR_W  = $clog2(ENTRIES + 1);
   localparam int SPAN   = 1 << IDX_W;

   if (ENTRIES != SPAN / 2 + 1) begin : g_bad_entries
      $error("coefficient entries must cover half the phase span plus one");
   end
   if (WORD_W < PTR_W) begin : g_bad_word
      $error("coefficient word too narrow for the index");
   end

   logic [WORD_W-1:0] bank [ENTRIES];
   logic [PTR_W-1:0]  ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
         for (int e = 0; e < ENTRIES; e++) bank[e] <= '0;
      end else if (wr_en) begin
         if (wr_sel == COEF_PORT_INDEX) begin
            ptr <= (wr_data >= WORD_W'(ENTRIES)) ? PTR_W'(ENTRIES) : wr_data[PTR_W-1:0];
         end else if (ptr < PTR_W'(ENTRIES)) begin
            bank[ptr] <= wr_data;
            ptr       <= ptr + PTR_W'(1);
         end
      end
   end

   // phase lookup with mirroring of the upper half
   logic             mirror;
   logic [IDX_W:0]   entry_w;
   logic [PTR_W-1:0] entry;
   logic [WORD_W-1:0] word;

   always_comb begin
      mirror  = {1'b0, ph_idx} > (IDX_W+1)'(ENTRIES - 1);
      entry_w = mirror ? ((IDX_W+1)'(SPAN) - {1'b0, ph_idx}) : {1'b0, ph_idx};
      entry   = PTR_W'(entry_w);
      word    = bank[entry];
   end

   for (genvar i = 0; i < TAPS; i++) begin : g_lane
      assign taps_flat[(TAPS-1-i)*COEF_W +: COEF_W] =
         mirror ? word[i*COEF_W +: COEF_W] : word[(TAPS-1-i)*COEF_W +: COEF_W];
   end

   // R2: pointer never runs past the table
   p_ptr_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= PTR_W'(ENTRIES));

   // R2: a data write below the end advances the pointer by one
   p_data_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == COEF_PORT_DATA && ptr < PTR_W'(ENTRIES))
      |=> ptr == $past(ptr) + PTR_W'(1));
endmodule

// File: rtl/ovl_rs_line_store.sv
module ovl_rs_line_store #(
   parameter int PIX_W = 8,
   parameter int MAX_W = 64,
   parameter int TAPS  = 4,
   parameter int POS_W = 11
) (
   input  logic                           clk,
   input  logic                           wr_en,
   input  logic [$clog2(MAX_W)-1:0]       wr_addr,
   input  logic [PIX_W-1:0]               wr_data,
   input  logic [POS_W-1:0]               centre,
   input  logic [$clog2(MAX_W)-1:0]       last_idx,
   output logic [TAPS*PIX_W-1:0]          rd_flat
);
   localparam int ADDR_W = $clog2(MAX_W);
   localparam int IX_W   = POS_W + 2;
   localparam int LEAD   = TAPS / 2 - 1;

   if (IX_W <= ADDR_W) begin : g_bad_pos
      $error("position width must exceed the address width");
   end

   logic [PIX_W-1:0] mem [MAX_W];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   logic signed [IX_W-1:0] last_x;
   assign last_x = $signed({{(IX_W-ADDR_W){1'b0}}, last_idx});

   for (genvar i = 0; i < TAPS; i++) begin : g_rd
      logic signed [IX_W-1:0] want;
      logic [ADDR_W-1:0]      addr;
      always_comb begin
         want = $signed({2'b00, centre}) + IX_W'(i) - IX_W'(LEAD);
         if (want < 0)           addr = '0;
         else if (want > last_x) addr = last_idx;
         else                    addr = want[ADDR_W-1:0];
      end
      assign rd_flat[(TAPS-1-i)*PIX_W +: PIX_W] = mem[addr];
   end
endmodule

// File: rtl/ovl_rs_mac.sv
module ovl_rs_mac #(
   parameter int TAPS   = 4,
   parameter int COEF_W = 8,
   parameter int PIX_W  = 8,
   parameter int FRAC   = 7
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [TAPS*COEF_W-1:0]  taps_flat,
   input  logic [TAPS*PIX_W-1:0]   pix_flat,
   output logic [PIX_W-1:0]        result
);
   localparam int TAP_X  = COEF_W + 1;
   localparam int PROD_W = TAP_X + PIX_W + 1;
   localparam int SUM_W  = PROD_W + $clog2(TAPS) + 1;
   localparam int LEAD   = TAPS / 2 - 1;
   localparam logic [COEF_W-1:0] FULL_CODE = COEF_W'(1) << (COEF_W - 1);
   localparam logic [TAPS*COEF_W-1:0] UNITY =
      (TAPS*COEF_W)'(FULL_CODE) << ((TAPS-1-LEAD)*COEF_W);
   localparam logic signed [SUM_W-1:0] ROUND = SUM_W'(1) << (FRAC - 1);
   localparam logic signed [SUM_W-1:0] TOP   = SUM_W'((1 << PIX_W) - 1);

   if (FRAC != COEF_W - 1) begin : g_bad_frac
      $error("unity gain must be the full-scale tap code");
   end

   logic signed [PROD_W-1:0] prod [TAPS];

   for (genvar i = 0; i < TAPS; i++) begin : g_tap
      logic [COEF_W-1:0]        raw;
      logic signed [TAP_X-1:0]  tap_x;
      logic signed [PIX_W:0]    pix_x;
      assign raw   = taps_flat[(TAPS-1-i)*COEF_W +: COEF_W];
      // the full-scale code stands for +unity, never for its negative
      assign tap_x = (raw == FULL_CODE) ? $signed({1'b0, raw}) : $signed({raw[COEF_W-1], raw});
      assign pix_x = $signed({1'b0, pix_flat[(TAPS-1-i)*PIX_W +: PIX_W]});
      assign prod[i] = tap_x * pix_x;
   end

   logic signed [SUM_W-1:0] acc;
   logic signed [SUM_W-1:0] rounded;

   always_comb begin
      acc = '0;
      for (int i = 0; i < TAPS; i++) acc = acc + SUM_W'(prod[i]);
      rounded = (acc + ROUND) >>> FRAC;
      if (rounded < 0)        result = '0;
      else if (rounded > TOP) result = '1;
      else                    result = rounded[PIX_W-1:0];
   end

   // R11: the full-scale centre tap passes the centre pixel unchanged
   p_unity_tap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (taps_flat == UNITY) |-> result == pix_flat[(TAPS-1-LEAD)*PIX_W +: PIX_W]);
endmodule

// File: rtl/ovl_rs_phase.sv
module ovl_rs_phase #(
   parameter int STEP_W = 28,
   parameter int ACC_W  = 35,
   parameter int FRAC   = 24,
   parameter int IDX_W  = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    adv,
   input  logic [STEP_W-1:0]       step,
   output logic [ACC_W-FRAC-1:0]   pos,
   output logic [IDX_W-1:0]        ph_idx
);
   if (ACC_W <= STEP_W || FRAC < IDX_W) begin : g_bad_acc
      $error("accumulator must be wider than the step and hold the index");
   end

   logic [ACC_W-1:0] acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc <= '0;
      else if (clr) acc <= '0;
      else if (adv) acc <= acc + ACC_W'(step);
   end

   assign pos    = acc[ACC_W-1:FRAC];
   assign ph_idx = acc[FRAC-1 -: IDX_W];

   // R5: each advance with a nonzero step moves the position forward
   p_acc_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !clr && step != '0) |=> acc > $past(acc));
endmodule

// File: rtl/ovl_hresampler.sv
module ovl_hresampler
   import ovl_rs_pkg::*;
#(
   parameter int PIX_W     = 8,
   parameter int MAX_W     = 64,
   parameter int TAPS      = 4,
   parameter int COEF_W    = 8,
   parameter int COEF_FRAC = 7,
   parameter int ENTRIES   = 33,
   parameter int IDX_W     = 6,
   parameter int PH_FRAC   = 24,
   parameter int STEP_W    = 28
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_scale_en,
   input  logic                          cfg_path_en,
   input  logic [$clog2(MAX_W+1)-1:0]    cfg_src_width,
   input  logic [$clog2(MAX_W+1)-1:0]    cfg_dst_width,
   input  logic [STEP_W-1:0]             cfg_step,
   input  logic                          coef_wr,
   input  logic                          coef_sel,
   input  logic [TAPS*COEF_W-1:0]        coef_wdata,
   input  logic                          in_valid,
   output logic                          in_ready,
   input  logic [PIX_W-1:0]              in_data,
   output logic                          out_valid,
   input  logic                          out_ready,
   output logic [PIX_W-1:0]              out_data
);
   localparam int WIDTH_W = $clog2(MAX_W + 1);
   localparam int ADDR_W  = $clog2(MAX_W);
   localparam int ACC_W   = STEP_W + WIDTH_W;
   localparam int POS_W   = ACC_W - PH_FRAC;

   if (TAPS != 4) begin : g_bad_taps
      $error("filter bank length must be four taps");
   end
   if (STEP_W <= PH_FRAC) begin : g_bad_step
      $error("step needs integer bits above the fraction");
   end

   rs_state_e           state;
   logic [WIDTH_W-1:0]  wr_cnt;
   logic [WIDTH_W-1:0]  emit_cnt;
   logic                ov_q;
   logic [PIX_W-1:0]    od_q;

   logic bypass, eng_ready, fill_acc, fill_last, slot_free, load, done;

   always_comb begin
      bypass    = !(cfg_scale_en && cfg_path_en);
      eng_ready = !bypass && out_ready;
      fill_acc  = !bypass && (state == RS_FILL) && in_valid;
      fill_last = fill_acc && (wr_cnt == cfg_src_width - WIDTH_W'(1));
      slot_free = !ov_q || eng_ready;
      load      = (state == RS_EMIT) && (emit_cnt < cfg_dst_width) && slot_free;
      done      = (state == RS_EMIT) && (emit_cnt == cfg_dst_width) && slot_free;
   end

   logic [POS_W-1:0]          centre;
   logic [IDX_W-1:0]          ph_idx;
   logic [TAPS*COEF_W-1:0]    taps_flat;
   logic [TAPS*PIX_W-1:0]     pix_flat;
   logic [PIX_W-1:0]          mac_out;

   ovl_rs_phase #(
      .STEP_W (STEP_W),
      .ACC_W  (ACC_W),
      .FRAC   (PH_FRAC),
      .IDX_W  (IDX_W)
   ) i_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (done),
      .adv    (load),
      .step   (cfg_step),
      .pos    (centre),
      .ph_idx (ph_idx)
   );

   ovl_rs_coef_bank #(
      .ENTRIES (ENTRIES),
      .TAPS    (TAPS),
      .COEF_W  (COEF_W),
      .IDX_W   (IDX_W)
   ) i_coef (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (coef_wr),
      .wr_sel    (coef_sel),
      .wr_data   (coef_wdata),
      .ph_idx    (ph_idx),
      .taps_flat (taps_flat)
   );

   ovl_rs_line_store #(
      .PIX_W (PIX_W),
      .MAX_W (MAX_W),
      .TAPS  (TAPS),
      .POS_W (POS_W)
   ) i_store (
      .clk      (clk),
      .wr_en    (fill_acc),
      .wr_addr  (wr_cnt[ADDR_W-1:0]),
      .wr_data  (in_data),
      .centre   (centre),
      .last_idx (ADDR_W'(cfg_src_width - WIDTH_W'(1))),
      .rd_flat  (pix_flat)
   );

   ovl_rs_mac #(
      .TAPS   (TAPS),
      .COEF_W (COEF_W),
      .PIX_W  (PIX_W),
      .FRAC   (COEF_FRAC)
   ) i_mac (
      .clk       (clk),
      .rst_n     (rst_n),
      .taps_flat (taps_flat),
      .pix_flat  (pix_flat),
      .result    (mac_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RS_FILL;
         wr_cnt   <= '0;
         emit_cnt <= '0;
         ov_q     <= 1'b0;
         od_q     <= '0;
      end else begin
         if (fill_acc) begin
            wr_cnt <= fill_last ? '0 : wr_cnt + WIDTH_W'(1);
            if (fill_last) state <= RS_EMIT;
         end
         if (ov_q && eng_ready) ov_q <= 1'b0;
         if (load) begin
            od_q     <= mac_out;
            ov_q     <= 1'b1;
            emit_cnt <= emit_cnt + WIDTH_W'(1);
         end
         if (done) begin
            state    <= RS_FILL;
            emit_cnt <= '0;
         end
      end
   end

   assign in_ready  = bypass ? out_ready : (state == RS_FILL);
   assign out_valid = bypass ? in_valid  : ov_q;
   assign out_data  = bypass ? in_data   : od_q;

   // R9: a stalled output keeps its value
   p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ov_q && !eng_ready) |=> (ov_q && $stable(od_q)));

   // R4: fill count stays inside the line store
   p_fill_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt < WIDTH_W'(MAX_W));

   // R4: no more outputs than the destination width
   p_emit_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      emit_cnt <= cfg_dst_width);
endmodule

// File: tb/test_ovl_hresampler.sv
module test_ovl_hresampler;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_scale_en = 1'b1;
   logic        cfg_path_en = 1'b1;
   logic [6:0]  cfg_src_width = 7'd16;
   logic [6:0]  cfg_dst_width = 7'd16;
   logic [27:0] cfg_step = 28'h1000000;
   logic        coef_wr = 1'b0;
   logic        coef_sel = 1'b0;
   logic [31:0] coef_wdata = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [7:0]  in_data = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [7:0]  out_data;

   int vectors = 0;
   int fails = 0;

   always #4 clk = ~clk;

   ovl_hresampler i_ovl_hresampler (
      .clk(clk), .rst_n(rst_n),
      .cfg_scale_en(cfg_scale_en), .cfg_path_en(cfg_path_en),
      .cfg_src_width(cfg_src_width), .cfg_dst_width(cfg_dst_width),
      .cfg_step(cfg_step),
      .coef_wr(coef_wr), .coef_sel(coef_sel), .coef_wdata(coef_wdata),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // bench coefficient set: entry 0 = (0,128,0,0), entry 32 = (-8,72,72,-8)
   function automatic int tb_tap(int k, int i);
      int a = k >> 2;
      case (i)
         0: return -a;
         1: return 128 + 2*a - (2*k + a);
         2: return 2*k + a;
         default: return -a;
      endcase
   endfunction

   function automatic logic [31:0] tb_word(int k);
      return {8'(tb_tap(k,0)), 8'(tb_tap(k,1)), 8'(tb_tap(k,2)), 8'(tb_tap(k,3))};
   endfunction

   function automatic int pix_of(int pat, int j);
      case (pat)
         0: return (j*13 + 7) & 255;
         1: return ((j/3) % 2) ? 255 : 0;
         default: return ((j*37) ^ 8'h5c) & 255;
      endcase
   endfunction

   function automatic int model(int n, int src, longint step, int pat);
      longint acc = longint'(n) * step;
      int pos = int'(acc >> 24);
      int idx = int'((acc >> 18) & 63);
      int sum = 0;
      int r;
      for (int i = 0; i < 4; i++) begin
         int ti = (idx <= 32) ? tb_tap(idx, i) : tb_tap(64 - idx, 3 - i);
         int p = pos - 1 + i;
         if (p < 0) p = 0;
         if (p > src - 1) p = src - 1;
         sum += ti * pix_of(pat, p);
      end
      r = (sum + 64) >>> 7;
      if (r < 0) r = 0;
      if (r > 255) r = 255;
      return r;
   endfunction

   task automatic coef_write(input logic sel, input logic [31:0] d);
      @(negedge clk);
      coef_wr = 1'b1; coef_sel = sel; coef_wdata = d;
      @(negedge clk);
      coef_wr = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
      check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
   endtask

   task automatic t_load_table();
      coef_write(1'b0, 32'd0);
      for (int k = 0; k < 33; k++) coef_write(1'b1, tb_word(k));
      // R2: pointer is at the end; this write must be dropped, not wrap to entry 0
      coef_write(1'b1, 32'h7f7f7f7f);
      // R2: out-of-range index saturates; data after it is dropped too
      coef_write(1'b0, 32'd40);
      coef_write(1'b1, 32'h11223344);
   endtask

   task automatic run_line(input int src, input int dst, input int pat, input bit bp, input string tag);
      longint st = (longint'(src) << 24) / dst;
      int n = 0;
      int cyc = 0;
      bit hold_pending = 0;
      int held = 0;
      @(negedge clk);
      cfg_src_width = 7'(src);
      cfg_dst_width = 7'(dst);
      cfg_step = 28'(st);
      out_ready = 1'b0;
      for (int j = 0; j < src; j++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data = 8'(pix_of(pat, j));
         while (!in_ready) @(negedge clk);
         @(posedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid == 1'b0, {"R9 no output yet ", tag}, int'(out_valid), 0);
      check(in_ready == 1'b0, {"R4 input closed while emitting ", tag}, int'(in_ready), 0);
      @(negedge clk);
      check(out_valid == 1'b1, {"R9 first output one clock after line ", tag}, int'(out_valid), 1);
      while (n < dst && cyc < 2000) begin
         out_ready = bp ? (cyc % 3 != 2) : 1'b1;
         #1;
         if (hold_pending)
            check(out_valid && int'(out_data) == held, {"R9 stalled output holds ", tag}, int'(out_data), held);
         hold_pending = 0;
         if (out_valid) begin
            if (out_ready) begin
               int exp = model(n, src, st, pat);
               check(int'(out_data) == exp, {"R5/R6/R7/R8 pixel ", tag}, int'(out_data), exp);
               n++;
            end else begin
               hold_pending = 1;
               held = int'(out_data);
            end
         end
         @(negedge clk);
         cyc++;
      end
      check(n == dst, {"R4 output count ", tag}, n, dst);
      out_ready = 1'b0;
      check(in_ready == 1'b1, {"R4 input reopens after line ", tag}, int'(in_ready), 1);
   endtask

   task automatic t_bypass();
      @(negedge clk);
      cfg_scale_en = 1'b0;
      in_valid = 1'b1; in_data = 8'h5a; out_ready = 1'b0;
      #1;
      check(out_valid == 1'b1, "R3 valid passes (scale off)", int'(out_valid), 1);
      check(out_data == 8'h5a, "R3 data passes (scale off)", int'(out_data), 'h5a);
      check(in_ready == 1'b0, "R3 ready follows (scale off)", int'(in_ready), 0);
      @(negedge clk);
      cfg_scale_en = 1'b1; cfg_path_en = 1'b0;
      in_data = 8'hc3; out_ready = 1'b1;
      #1;
      check(out_data == 8'hc3, "R3 data passes (path off)", int'(out_data), 'hc3);
      check(in_ready == 1'b1, "R3 ready follows (path off)", int'(in_ready), 1);
      @(negedge clk);
      in_valid = 1'b0;
      #1;
      check(out_valid == 1'b0, "R3 valid low passes", int'(out_valid), 0);
      @(negedge clk);
      cfg_path_en = 1'b1; out_ready = 1'b0;
      #1;
      check(out_valid == 1'b0, "R3 engine took nothing in bypass", int'(out_valid), 0);
      check(in_ready == 1'b1, "R3 engine still filling", int'(in_ready), 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_load_table();
      run_line(16, 16, 0, 1'b0, "R10 unity 16->16");
      run_line(16, 32, 1, 1'b0, "R7 2x 16->32");
      run_line(12, 32, 1, 1'b0, "R6 R11 mirror 12->32");
      run_line(24, 16, 2, 1'b1, "R9 down 24->16 stalled");
      t_bypass();
      run_line(5, 13, 2, 1'b1, "R7 edges 5->13");
      run_line(16, 16, 2, 1'b0, "R2 entry0 intact");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule